// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter with Byte-Wide Register Access

This block is a 16-bit up-counter that software reaches through an 8-bit register bus. It counts one of two sources. The first is the internal instruction clock, which runs at a quarter of the system clock. The second is the rising edges of an external clock pin. A 2-bit field picks a divide ratio of 1, 2, 4 or 8, and that divider sits in front of the counter. The external pin reaches the counter in one of two ways: through a two-flop synchroniser, which gives a synchronous counter, or directly, which gives an asynchronous counter.

An enable bit gates counting. A trigger pulse from a neighbouring capture/compare unit clears the count, but only while the configuration input `trig_en_i` allows it. When the count wraps from all-ones to zero, a sticky wrap flag is set. In the 16-bit access mode, the high byte passes through a shadow buffer so that software reads and writes the count as one consistent 16-bit value.

Register addresses on `addr_i`:

| Address | Register |
|---|---|
| 0 | control |
| 1 | count low byte |
| 2 | count high byte |
| 3 | wrap flag (bit 0) |

Top module: `presc_tmr16`

## Requirements
- R1: After reset, every register reads as 0: the control byte, both count bytes and the wrap flag. `ovf_o` is low. `rdata_o` shows, without delay, the register selected by `addr_i` at addresses 0 to 3.
- R2: The control byte has these fields:
  - bit 0: enable.
  - bit 1: source select (0 = instruction clock, 1 = external pin).
  - bit 2: synchroniser select (1 = synchronised).
  - bits 5:4: divide code.
  - bit 7: 16-bit access mode.
  - Bits 3 and 6 always read 0.
- R3: With source select 0 and divide code 0, the count rises by exactly 1 every 4 system clocks.
- R4: Divide codes 0, 1, 2 and 3 give ratios of 1, 2, 4 and 8. A write to either count byte restarts the divider.
- R5: With source select 1 and synchroniser select 0, an external rising edge appears in the count right after the first clock edge that samples it high.
- R6: With synchroniser select 1, the same edge appears exactly two clocks later than in R5.
- R7: While the enable bit is 0, the count holds.
- R8: A trigger pulse clears the whole count only while `trig_en_i` is 1; otherwise it has no effect. A bus write to a count byte takes priority over the trigger, and the trigger takes priority over counting.
- R9: A wrap from 0xFFFF to 0x0000 sets the wrap flag. The flag stays set, and `ovf_o` follows it.
- R10: Writing a byte with bit 0 = 0 to address 3 clears the flag, and writing bit 0 = 1 leaves it unchanged. If a wrap and a clear occur in the same cycle, the flag ends up set.
- R11: In 16-bit mode, reading the low byte copies the live high byte into the buffer, and reading address 2 returns the buffer.
- R12: In 16-bit mode, writing address 2 loads only the buffer and leaves the count unchanged. Writing the low byte loads {buffer, data} into the count.
- R13: Outside 16-bit mode, address 2 reads and writes the live high byte directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_clk_i | input | 1 | External count input |
| trig_i | input | 1 | Clear pulse from the capture/compare unit |
| trig_en_i | input | 1 | Allows `trig_i` to clear this timer |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (marks a read for the buffer latch) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| ovf_o | output | 1 | Wrap flag |

## Verification
The hardest case to reach is a tear in a 16-bit read, where the count carries into the high byte between the two byte reads. The bench produces it deterministically. It loads 0x01FF, reads the low byte, delivers exactly one asynchronous external edge, and only then reads the high byte. The wrap-versus-clear race is reached in a similar way: a bus clear of the flag is placed in the same cycle as the edge that wraps the count. Sync and async latency are measured by holding the pin high and sampling the count at each clock that follows.

// File: rtl/presc_tmr16_pkg.sv
package presc_tmr16_pkg;
  localparam int unsigned AW = 2;
  localparam logic [AW-1:0] A_CTL = 2'd0;
  localparam logic [AW-1:0] A_LO  = 2'd1;
  localparam logic [AW-1:0] A_HI  = 2'd2;
  localparam logic [AW-1:0] A_FLG = 2'd3;

  localparam int unsigned B_EN   = 0;
  localparam int unsigned B_SRC  = 1;
  localparam int unsigned B_SYNC = 2;
  localparam int unsigned B_DIV  = 4;   // 2-bit field at 5:4
  localparam int unsigned B_W16  = 7;
  localparam logic [7:0]  CTL_MASK = 8'hB7;
endpackage

// File: rtl/presc_tmr16_src.sv
module presc_tmr16_src #(
  parameter int unsigned IDIV   = 4,
  parameter int unsigned NSYNC  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  input  logic src_ext_i,
  input  logic sync_i,
  output logic tick_o
);
  localparam int unsigned DW = (IDIV > 1) ? $clog2(IDIV) : 1;

  logic icyc_tick;

  generate
    if (IDIV > 1) begin : g_idiv
      logic [DW-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_q + DW'(1);
      assign icyc_tick = (div_q == DW'(IDIV - 1));
    end else begin : g_nodiv
      assign icyc_tick = 1'b1;
    end
  endgenerate

  logic [NSYNC-1:0] sy_q;
  logic             sy_last_q, raw_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sy_q      <= '0;
      sy_last_q <= 1'b0;
      raw_q     <= 1'b0;
    end else begin
      sy_q[0] <= ext_i;
      for (int i = 1; i < NSYNC; i++) sy_q[i] <= sy_q[i-1];
      sy_last_q <= sy_q[NSYNC-1];
      raw_q     <= ext_i;
    end

  logic edge_sync, edge_raw;
  assign edge_sync = sy_q[NSYNC-1] & ~sy_last_q;
  assign edge_raw  = ext_i & ~raw_q;  // async path: no resync stage

  assign tick_o = src_ext_i ? (sync_i ? edge_sync : edge_raw) : icyc_tick;
endmodule

// File: rtl/presc_tmr16_div.sv
module presc_tmr16_div #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned CW = (1 << SEL_W) - 1;

  logic [CW-1:0] cnt_q, lim;
  assign lim    = (CW'(1) << sel_i) - CW'(1);
  assign tick_o = tick_i && (cnt_q == lim);  // sel 0: lim 0, bypass

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == lim) ? '0 : cnt_q + CW'(1);
endmodule

// File: rtl/presc_tmr16.sv
module presc_tmr16
  import presc_tmr16_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned IDIV  = 4,
  parameter int unsigned NSYNC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ext_clk_i,
  input  logic          trig_i,
  input  logic          trig_en_i,
  input  logic [1:0]    addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          ovf_o
);
  localparam int unsigned CW = 2 * DW;

  logic [7:0]    ctrl_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] hbuf_q;
  logic          flag_q;

  logic w16, en;
  assign w16 = ctrl_q[B_W16];
  assign en  = ctrl_q[B_EN];

  logic wr_ctl, wr_lo, wr_hi, wr_flg, rd_lo, clr_trig, hi_direct;
  assign wr_ctl    = wr_i && (addr_i == A_CTL);
  assign wr_lo     = wr_i && (addr_i == A_LO);
  assign wr_hi     = wr_i && (addr_i == A_HI);
  assign wr_flg    = wr_i && (addr_i == A_FLG);
  assign rd_lo     = rd_i && (addr_i == A_LO);
  assign clr_trig  = trig_en_i && trig_i;
  assign hi_direct = wr_hi && !w16;

  logic src_tick, inc;

  presc_tmr16_src #(.IDIV(IDIV), .NSYNC(NSYNC)) src_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ext_i     (ext_clk_i),
    .src_ext_i (ctrl_q[B_SRC]),
    .sync_i    (ctrl_q[B_SYNC]),
    .tick_o    (src_tick)
  );

  presc_tmr16_div #(.SEL_W(2)) div_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (src_tick && en),
    .clr_i  (wr_lo || wr_hi),
    .sel_i  (ctrl_q[B_DIV+1:B_DIV]),
    .tick_o (inc)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     ctrl_q <= '0;
    else if (wr_ctl) ctrl_q <= wdata_i & CTL_MASK;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        cnt_q <= '0;
    else if (wr_lo)     cnt_q <= {(w16 ? hbuf_q : cnt_q[CW-1:DW]), wdata_i};
    else if (hi_direct) cnt_q[CW-1:DW] <= wdata_i;
    else if (clr_trig)  cnt_q <= '0;
    else if (inc)       cnt_q <= cnt_q + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)               hbuf_q <= '0;
    else if (w16 && rd_lo)     hbuf_q <= cnt_q[CW-1:DW];
    else if (w16 && wr_hi)     hbuf_q <= wdata_i;

  logic wrap;
  assign wrap = inc && (&cnt_q) && !wr_lo && !hi_direct && !clr_trig;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                     flag_q <= 1'b0;
    else if (wrap)                   flag_q <= 1'b1;   // set beats clear
    else if (wr_flg && !wdata_i[0])  flag_q <= 1'b0;

  always_comb begin
    unique case (addr_i)
      A_CTL:   rdata_o = ctrl_q;
      A_LO:    rdata_o = cnt_q[DW-1:0];
      A_HI:    rdata_o = w16 ? hbuf_q : cnt_q[CW-1:DW];
      default: rdata_o = {{(DW-1){1'b0}}, flag_q};
    endcase
  end

  assign ovf_o = flag_q;
endmodule

// File: rtl/presc_tmr16_chk.sv
module presc_tmr16_chk
  import presc_tmr16_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      addr_i,
  input logic            wr_i,
  input logic            rd_i,
  input logic [DW-1:0]   wdata_i,
  input logic            trig_i,
  input logic            trig_en_i,
  input logic [7:0]      ctrl_q,
  input logic [2*DW-1:0] cnt_q,
  input logic [DW-1:0]   hbuf_q,
  input logic            flag_q,
  input logic            ovf_o
);
  logic clr;
  assign clr = trig_en_i && trig_i;

  assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !(wr_i && addr_i == A_FLG) |=> flag_q);

  assert_wrap_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cnt_q) && !wr_i && !clr |=> (cnt_q != '0) || (flag_q && ovf_o));

  assert_hold_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[B_EN] && !wr_i && !clr |=> $stable(cnt_q));

  assert_trig_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr && !wr_i |=> cnt_q == '0);

  assert_step_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i && !clr |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));

  assert_rd_latch_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[B_W16] && rd_i && !wr_i && addr_i == A_LO |=> hbuf_q == $past(cnt_q[2*DW-1:DW]));

  assert_wr_pair_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[B_W16] && wr_i && addr_i == A_LO |=> cnt_q == {$past(hbuf_q), $past(wdata_i)});
endmodule

bind presc_tmr16 presc_tmr16_chk #(.DW(DW)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_i      (wr_i),
  .rd_i      (rd_i),
  .wdata_i   (wdata_i),
  .trig_i    (trig_i),
  .trig_en_i (trig_en_i),
  .ctrl_q    (ctrl_q),
  .cnt_q     (cnt_q),
  .hbuf_q    (hbuf_q),
  .flag_q    (flag_q),
  .ovf_o     (ovf_o)
);

// File: tb/presc_tmr16_tb_top.sv
module presc_tmr16_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext = 1'b0, trig = 1'b0, trig_en = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ovf;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  presc_tmr16 dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext), .trig_i(trig), .trig_en_i(trig_en),
    .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .ovf_o(ovf)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse();
    @(negedge clk); ext = 1'b1;
    @(negedge clk); ext = 1'b0;
  endtask

  task automatic zero_cnt();
    wreg(2'd2, 8'h00); wreg(2'd1, 8'h00);
  endtask

  // {div code[15:14], pulses[13:8], expected low byte[7:0]}, async external
  localparam logic [15:0] VEC [7] = '{
    {2'd0, 6'd7,  8'd7},
    {2'd1, 6'd5,  8'd2},
    {2'd1, 6'd6,  8'd3},
    {2'd2, 6'd9,  8'd2},
    {2'd2, 6'd3,  8'd0},
    {2'd3, 6'd17, 8'd2},
    {2'd3, 6'd8,  8'd1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, a, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    peek(2'd0, v); chk("R1 ctrl", v, 8'h00);
    peek(2'd1, v); chk("R1 lo", v, 8'h00);
    peek(2'd2, v); chk("R1 hi", v, 8'h00);
    peek(2'd3, v); chk("R1 flag", v, 8'h00);
    chk("R1 ovf_o", {7'd0, ovf}, 8'h00);

    // R2 reserved bits read 0
    wreg(2'd0, 8'hFE); peek(2'd0, v); chk("R2 ctrl mask", v, 8'hB6);
    wreg(2'd0, 8'h00);

    // R4/R5 table of ratios
    for (int i = 0; i < 7; i++) begin
      wreg(2'd0, 8'h00);
      zero_cnt();
      wreg(2'd0, 8'h03 | {2'b00, VEC[i][15:14], 4'h0});
      for (int p = 0; p < int'(VEC[i][13:8]); p++) pulse();
      peek(2'd1, v); chk("R4 ratio vector", v, VEC[i][7:0]);
    end

    // R4 counter write restarts divider
    wreg(2'd0, 8'h00); zero_cnt(); wreg(2'd0, 8'h13);
    pulse(); wreg(2'd1, 8'h00); pulse();
    peek(2'd1, v); chk("R4 divider restart", v, 8'h00);
    pulse(); peek(2'd1, v); chk("R4 divider after restart", v, 8'h01);

    // R5 async latency: count after one clock edge
    wreg(2'd0, 8'h00); zero_cnt(); wreg(2'd0, 8'h03);
    @(negedge clk); addr = 2'd1; ext = 1'b1;
    @(negedge clk); #1 chk("R5 async 1 edge", rdata, 8'h01);
    ext = 1'b0;

    // R6 sync latency: two clocks later
    wreg(2'd0, 8'h00); zero_cnt(); wreg(2'd0, 8'h07);
    @(negedge clk); addr = 2'd1; ext = 1'b1;
    @(negedge clk); #1 chk("R6 sync edge1", rdata, 8'h00);
    @(negedge clk); #1 chk("R6 sync edge2", rdata, 8'h00);
    @(negedge clk); #1 chk("R6 sync edge3", rdata, 8'h01);
    ext = 1'b0;

    // R3 instruction clock: 10 counts per 40 clocks, ratio 8: 4 per 128
    wreg(2'd0, 8'h00); zero_cnt(); wreg(2'd0, 8'h01);
    peek(2'd1, a); repeat (40) @(negedge clk); #1 b = rdata;
    chk("R3 icyc rate", b - a, 8'd10);
    wreg(2'd0, 8'h00); zero_cnt(); wreg(2'd0, 8'h31);
    peek(2'd1, a); repeat (128) @(negedge clk); #1 b = rdata;
    chk("R4 icyc ratio8", b - a, 8'd4);

    // R7 enable off holds
    wreg(2'd0, 8'h00); zero_cnt(); wreg(2'd0, 8'h02);
    pulse(); pulse(); pulse();
    peek(2'd1, v); chk("R7 hold lo", v, 8'h00);

    // R8 trigger
    wreg(2'd0, 8'h00); wreg(2'd2, 8'h12); wreg(2'd1, 8'h34);
    trig_en = 1'b0; @(negedge clk); trig = 1'b1; @(negedge clk); trig = 1'b0;
    peek(2'd1, v); chk("R8 trig masked", v, 8'h34);
    trig_en = 1'b1; @(negedge clk); trig = 1'b1; @(negedge clk); trig = 1'b0;
    peek(2'd1, v); chk("R8 trig lo", v, 8'h00);
    peek(2'd2, v); chk("R8 trig hi", v, 8'h00);
    @(negedge clk); trig = 1'b1; addr = 2'd1; wdata = 8'h55; wr = 1'b1;
    @(negedge clk); trig = 1'b0; wr = 1'b0;
    peek(2'd1, v); chk("R8 write beats trig", v, 8'h55);
    trig_en = 1'b0;

    // R9 wrap
    wreg(2'd0, 8'h03); wreg(2'd2, 8'hFF); wreg(2'd1, 8'hFF);
    peek(2'd3, v); chk("R9 flag before", v, 8'h00);
    pulse();
    peek(2'd1, v); chk("R9 wrap lo", v, 8'h00);
    peek(2'd3, v); chk("R9 flag set", v, 8'h01);
    chk("R9 ovf_o", {7'd0, ovf}, 8'h01);
    pulse(); peek(2'd3, v); chk("R9 sticky", v, 8'h01);

    // R10 clear rules
    wreg(2'd3, 8'h01); peek(2'd3, v); chk("R10 write1 no effect", v, 8'h01);
    wreg(2'd3, 8'h00); peek(2'd3, v); chk("R10 clear", v, 8'h00);
    wreg(2'd2, 8'hFF); wreg(2'd1, 8'hFF);
    @(negedge clk); ext = 1'b1; addr = 2'd3; wdata = 8'h00; wr = 1'b1;
    @(negedge clk); ext = 1'b0; wr = 1'b0;
    peek(2'd3, v); chk("R10 set wins", v, 8'h01);
    wreg(2'd3, 8'h00);

    // R11/R12 16-bit mode
    wreg(2'd0, 8'h83); wreg(2'd2, 8'h01); wreg(2'd1, 8'hFF);
    rreg(2'd1, v); chk("R12 pair write lo", v, 8'hFF);
    pulse();
    rreg(2'd2, v); chk("R11 buffered hi", v, 8'h01);
    rreg(2'd1, v); chk("R11 lo after carry", v, 8'h00);
    rreg(2'd2, v); chk("R11 hi relatched", v, 8'h02);
    wreg(2'd2, 8'h55); wreg(2'd0, 8'h03);
    peek(2'd2, v); chk("R12 hi write buffered only", v, 8'h02);

    // R13 direct high byte
    wreg(2'd2, 8'h7A);
    peek(2'd2, v); chk("R13 direct hi", v, 8'h7A);
    peek(2'd1, v); chk("R13 lo untouched", v, 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule